// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block forms the second operand of a data-processing instruction. It takes an operand, a two-bit shift kind, a shift amount and the incoming carry flag, and returns the shifted operand together with the shifter carry-out. The amount comes either from a five-bit field in the instruction or from a full register value. The two sources give an amount of zero different meanings. Amounts of the full word width and above produce defined results and carries.

The block also chooses the operand values when register index 15, the program counter, is named. As the shifted source, the program counter is merged with the status bits. As the amount source, the program counter is advanced by 8 and the status bits are cleared. The result and the carry are captured in a register, so they appear one clock after the inputs. Register-file reads, the ALU and flag write-back are handled by other blocks.

Top module: `shf_top`

## Requirements
- R1: While `rst_n` is low, both outputs read zero. Each result appears on the outputs on the first rising clock edge after its inputs are applied.
- R2: Shift kind encoding: 00 is left logical, 01 is right logical, 10 is right arithmetic and 11 is rotate right. A right logical shift by an amount from 1 to 31 fills the top with zeros, and its carry is operand bit (amount-1).
- R3: A right logical shift by exactly 32 gives zero with carry equal to operand bit 31. Any larger amount gives zero with carry zero.
- R4: An immediate right logical shift with amount field 0 acts as a shift by 32: the result is zero and the carry is operand bit 31.
- R5: When `amt_from_reg`=1 and the amount value is 0, the operand passes through unchanged and the carry equals `carry_in`. This holds for all four shift kinds.
- R6: A left logical shift by 1 to 31 gives carry equal to bit (32-amount). A shift by 32 gives zero with carry equal to bit 0. A shift above 32 gives zero with carry zero. An immediate amount of 0 passes the operand and `carry_in` through.
- R7: A right arithmetic shift by 1 to 31 copies bit 31 into the vacated bits, and its carry is bit (amount-1). A shift by 32 or more, or an immediate amount of 0, fills every bit with bit 31, and the carry is bit 31.
- R8: A rotate right by a nonzero amount rotates by the amount modulo 32, and the carry equals result bit 31.
- R9: An immediate rotate with amount field 0 rotates by one place through the carry. `carry_in` enters bit 31, and the old bit 0 becomes the carry.
- R10: When `amt_idx`=15 and `amt_from_reg`=1, the amount used is (`pc_val`+8) with the status bits cleared. The status bits are the bits outside `PC_MASK` (default 32'h03FF_FFFC).
- R11: When `op_idx`=15, the operand used is `pc_val` inside `PC_MASK` merged with `psr_bits` outside `PC_MASK`. `op_data` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_kind | input | 2 | Shift kind (see R2) |
| carry_in | input | 1 | Current carry flag |
| op_idx | input | 4 | Register index of the shifted operand |
| op_data | input | 32 | Register value of the shifted operand |
| amt_from_reg | input | 1 | 1: amount comes from a register; 0: from the immediate field |
| amt_imm | input | 5 | Immediate shift amount |
| amt_idx | input | 4 | Register index of the amount |
| amt_data | input | 32 | Register value of the amount |
| pc_val | input | 32 | Program counter |
| psr_bits | input | 32 | Status bits, used outside PC_MASK |
| res_q | output | 32 | Registered shifted operand |
| carry_q | output | 1 | Registered shifter carry-out |

## Verification
Both program-counter substitutions can apply in the same cycle. In that case the operand carries the status bits and the amount does not. The bench names index 15 for both the operand and the amount, and picks a program counter whose advanced, masked value is zero. The cycle therefore also exercises the register-zero pass-through. The check passes only if the output equals the merged program counter and status value, and the carry equals `carry_in`. A second case with a nonzero advanced value confirms that the cleared status bits do not leak into the amount.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [31:0] res;
        logic        cout;
    } shf_out_t;
endpackage

// File: rtl/shf_op_sel.sv
module shf_op_sel #(
    parameter int W = 32,
    parameter int IDX_W = 4,
    parameter int PC_IDX = 15,
    parameter logic [W-1:0] PC_MASK = 32'h03FF_FFFC
) (
    input  logic [IDX_W-1:0] op_idx,
    input  logic [W-1:0]     op_data,
    input  logic [W-1:0]     pc_val,
    input  logic [W-1:0]     psr_bits,
    output logic [W-1:0]     opnd
);
    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    always_comb begin
        if (op_idx == PC_SEL) begin
            opnd = (pc_val & PC_MASK) | (psr_bits & ~PC_MASK);
        end else begin
            opnd = op_data;
        end
    end
endmodule

// File: rtl/shf_amt_sel.sv
module shf_amt_sel #(
    parameter int W = 32,
    parameter int IDX_W = 4,
    parameter int PC_IDX = 15,
    parameter int PC_AHEAD = 8,
    parameter logic [W-1:0] PC_MASK = 32'h03FF_FFFC,
    localparam int AW = $clog2(W)
) (
    input  logic              amt_from_reg,
    input  logic [AW-1:0]     amt_imm,
    input  logic [IDX_W-1:0]  amt_idx,
    input  logic [W-1:0]      amt_data,
    input  logic [W-1:0]      pc_val,
    output logic [W-1:0]      amt_eff,
    output logic              imm_zero,
    output logic              reg_zero
);
    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);
    logic [W-1:0] reg_amt;

    always_comb begin
        if (amt_idx == PC_SEL) begin
            reg_amt = (pc_val + W'(PC_AHEAD)) & PC_MASK;
        end else begin
            reg_amt = amt_data;
        end
        if (amt_from_reg) begin
            amt_eff = reg_amt;
        end else begin
            amt_eff = W'(amt_imm);
        end
        imm_zero = !amt_from_reg && (amt_imm == '0);
        reg_zero = amt_from_reg && (reg_amt == '0);
    end
endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [1:0]   kind,
    input  logic [W-1:0] val,
    input  logic [W-1:0] amt,
    input  logic         imm_zero,
    input  logic         reg_zero,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam logic [AW:0] WV = (AW+1)'(W);

    logic [AW-1:0] lo;
    logic          at_w;
    logic          over_w;
    logic          sgn;

    always_comb begin
        lo     = amt[AW-1:0];
        at_w   = (amt == W'(W));
        over_w = (amt > W'(W));
        sgn    = val[W-1];
        res    = val;
        cout   = cin;
        if (!reg_zero) begin
            unique case (shift_kind_e'(kind))
                SK_LSL: begin
                    if (imm_zero) begin
                        res  = val;
                        cout = cin;
                    end else if (over_w) begin
                        res  = '0;
                        cout = 1'b0;
                    end else if (at_w) begin
                        res  = '0;
                        cout = val[0];
                    end else begin
                        res  = val << lo;
                        cout = val[AW'(WV - {1'b0, lo})];
                    end
                end
                SK_LSR: begin
                    if (over_w) begin
                        res  = '0;
                        cout = 1'b0;
                    end else if (at_w || imm_zero) begin
                        res  = '0;
                        cout = sgn;
                    end else begin
                        res  = val >> lo;
                        cout = val[lo - 1'b1];
                    end
                end
                SK_ASR: begin
                    if (at_w || over_w || imm_zero) begin
                        res  = {W{sgn}};
                        cout = sgn;
                    end else begin
                        res  = W'($signed(val) >>> lo);
                        cout = val[lo - 1'b1];
                    end
                end
                SK_ROR: begin
                    if (imm_zero) begin
                        res  = {cin, val[W-1:1]};
                        cout = val[0];
                    end else begin
                        res  = (val >> lo) | (val << (WV - {1'b0, lo}));
                        cout = res[W-1];
                    end
                end
                default: begin
                    res  = val;
                    cout = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/shf_top.sv
module shf_top
    import shf_pkg::*;
#(
    parameter int W = 32,
    parameter int IDX_W = 4,
    parameter int PC_IDX = 15,
    parameter int PC_AHEAD = 8,
    parameter logic [W-1:0] PC_MASK = 32'h03FF_FFFC,
    localparam int AW = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        shift_kind,
    input  logic              carry_in,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic [W-1:0]      op_data,
    input  logic              amt_from_reg,
    input  logic [AW-1:0]     amt_imm,
    input  logic [IDX_W-1:0]  amt_idx,
    input  logic [W-1:0]      amt_data,
    input  logic [W-1:0]      pc_val,
    input  logic [W-1:0]      psr_bits,
    output logic [W-1:0]      res_q,
    output logic              carry_q
);
    logic [W-1:0] opnd;
    logic [W-1:0] amt_eff;
    logic         imm_zero;
    logic         reg_zero;
    logic [W-1:0] core_res;
    logic         core_cout;

    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
    } st_t;

    st_t st_d, st_q;

    shf_op_sel #(.W(W), .IDX_W(IDX_W), .PC_IDX(PC_IDX), .PC_MASK(PC_MASK)) u_op (
        .op_idx   (op_idx),
        .op_data  (op_data),
        .pc_val   (pc_val),
        .psr_bits (psr_bits),
        .opnd     (opnd)
    );

    shf_amt_sel #(.W(W), .IDX_W(IDX_W), .PC_IDX(PC_IDX), .PC_AHEAD(PC_AHEAD),
                  .PC_MASK(PC_MASK)) u_amt (
        .amt_from_reg (amt_from_reg),
        .amt_imm      (amt_imm),
        .amt_idx      (amt_idx),
        .amt_data     (amt_data),
        .pc_val       (pc_val),
        .amt_eff      (amt_eff),
        .imm_zero     (imm_zero),
        .reg_zero     (reg_zero)
    );

    shf_core #(.W(W)) u_core (
        .kind     (shift_kind),
        .val      (opnd),
        .amt      (amt_eff),
        .imm_zero (imm_zero),
        .reg_zero (reg_zero),
        .cin      (carry_in),
        .res      (core_res),
        .cout     (core_cout)
    );

    always_comb begin
        st_d      = st_q;
        st_d.res  = core_res;
        st_d.cout = core_cout;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q   = st_q.res;
    assign carry_q = st_q.cout;
endmodule

// File: rtl/shf_chk.sv
module shf_chk #(
    parameter int W = 32,
    parameter int IDX_W = 4,
    parameter int PC_IDX = 15,
    localparam int AW = $clog2(W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        shift_kind,
    input logic              carry_in,
    input logic [IDX_W-1:0]  op_idx,
    input logic [W-1:0]      op_data,
    input logic              amt_from_reg,
    input logic [AW-1:0]     amt_imm,
    input logic [IDX_W-1:0]  amt_idx,
    input logic [W-1:0]      amt_data,
    input logic [W-1:0]      res_q,
    input logic              carry_q
);
    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    // R5
    reg_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_from_reg && amt_idx != PC_SEL && op_idx != PC_SEL && amt_data == '0)
        |=> (res_q == $past(op_data) && carry_q == $past(carry_in)));

    // R3
    lsr_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == 2'b01 && amt_from_reg && amt_idx != PC_SEL && amt_data > W'(W))
        |=> (res_q == '0 && !carry_q));

    // R4
    lsr_imm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == 2'b01 && !amt_from_reg && amt_imm == '0 && op_idx != PC_SEL)
        |=> (res_q == '0 && carry_q == $past(op_data[W-1])));

    // R7
    asr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == 2'b10 && !amt_from_reg && amt_imm == '0)
        |=> ((res_q == '0 && !carry_q) || (res_q == '1 && carry_q)));

    // R8
    ror_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == 2'b11 && amt_from_reg && amt_idx != PC_SEL && amt_data != '0)
        |=> (carry_q == res_q[W-1]));

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n && $past(!rst_n)) begin
            reset_zero_chk: assert (res_q == '0 && !carry_q);
        end
    end
endmodule

bind shf_top shf_chk #(.W(W), .IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_kind   (shift_kind),
    .carry_in     (carry_in),
    .op_idx       (op_idx),
    .op_data      (op_data),
    .amt_from_reg (amt_from_reg),
    .amt_imm      (amt_imm),
    .amt_idx      (amt_idx),
    .amt_data     (amt_data),
    .res_q        (res_q),
    .carry_q      (carry_q)
);

// File: tb/tb_shf_top.sv
module tb_shf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  shift_kind = 2'b00;
    logic        carry_in = 1'b0;
    logic [3:0]  op_idx = 4'd0;
    logic [31:0] op_data = '0;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  amt_imm = '0;
    logic [3:0]  amt_idx = 4'd0;
    logic [31:0] amt_data = '0;
    logic [31:0] pc_val = '0;
    logic [31:0] psr_bits = '0;
    logic [31:0] res_q;
    logic        carry_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shf_top dut (
        .clk(clk), .rst_n(rst_n), .shift_kind(shift_kind), .carry_in(carry_in),
        .op_idx(op_idx), .op_data(op_data), .amt_from_reg(amt_from_reg),
        .amt_imm(amt_imm), .amt_idx(amt_idx), .amt_data(amt_data),
        .pc_val(pc_val), .psr_bits(psr_bits), .res_q(res_q), .carry_q(carry_q)
    );

    task automatic chk(input string req, input logic [31:0] er, input logic ec);
        n_cmp++;
        if (res_q !== er || carry_q !== ec) begin
            n_bad++;
            $display("FAIL %s: got res=%h c=%b, expected res=%h c=%b",
                     req, res_q, carry_q, er, ec);
        end
    endtask

    // drive at negedge, result registered at next posedge, sample at following negedge
    task automatic apply(input logic [1:0] k, input logic [31:0] d, input logic reg_src,
                         input logic [31:0] amt, input logic ci);
        @(negedge clk);
        shift_kind = k; op_data = d; op_idx = 4'd1; amt_idx = 4'd2;
        amt_from_reg = reg_src; carry_in = ci;
        if (reg_src) amt_data = amt; else amt_imm = amt[4:0];
        @(negedge clk);
    endtask

    function automatic logic [32:0] model(input logic [1:0] k, input logic [31:0] v,
                                          input logic reg_src, input logic [31:0] a,
                                          input logic ci);
        logic [31:0] r;
        logic c;
        int n;
        r = v; c = ci;
        if (reg_src && a == 0) return {ci, v};
        case (k)
            2'b00: if (a == 0) begin r = v; c = ci; end
                   else if (a > 32) begin r = 0; c = 0; end
                   else if (a == 32) begin r = 0; c = v[0]; end
                   else begin n = int'(a); r = v << n; c = v[32-n]; end
            2'b01: if (a > 32) begin r = 0; c = 0; end
                   else if (a == 32 || a == 0) begin r = 0; c = v[31]; end
                   else begin n = int'(a); r = v >> n; c = v[n-1]; end
            2'b10: if (a >= 32 || a == 0) begin r = {32{v[31]}}; c = v[31]; end
                   else begin n = int'(a); r = 32'($signed(v) >>> n); c = v[n-1]; end
            default: if (a == 0) begin r = {ci, v[31:1]}; c = v[0]; end
                   else begin n = int'(a % 32); r = (v >> n) | (v << (32 - n)); c = r[31]; end
        endcase
        return {c, r};
    endfunction

    task automatic t_reset;
        chk("R1 reset", 32'h0, 1'b0);
        rst_n = 1'b1;
        apply(2'b01, 32'h12345678, 1'b0, 4, 1'b0);
        chk("R1 one-cycle latency", 32'h01234567, 1'b1);
    endtask

    task automatic t_lsr;
        apply(2'b01, 32'h12345678, 1'b0, 4, 1'b0); chk("R2 lsr4 a", 32'h01234567, 1'b1);
        apply(2'b01, 32'h01234567, 1'b0, 4, 1'b1); chk("R2 lsr4 b", 32'h00123456, 1'b0);
        apply(2'b01, 32'h08003001, 1'b0, 1, 1'b0); chk("R2 lsr1", 32'h04001800, 1'b1);
        apply(2'b01, 32'hFFFFFFFF, 1'b1, 32, 1'b0); chk("R3 lsr32 set", 32'h0, 1'b1);
        apply(2'b01, 32'h7FFFFFFF, 1'b1, 32, 1'b1); chk("R3 lsr32 clr", 32'h0, 1'b0);
        apply(2'b01, 32'hFFFFFFFF, 1'b1, 33, 1'b1); chk("R3 lsr33", 32'h0, 1'b0);
        apply(2'b01, 32'hFFFFFFFF, 1'b1, 32'h100, 1'b1); chk("R3 lsr256", 32'h0, 1'b0);
        apply(2'b01, 32'hFFFFFFFF, 1'b0, 0, 1'b0); chk("R4 lsr imm0", 32'h0, 1'b1);
    endtask

    task automatic t_reg_zero;
        for (int k = 0; k < 4; k++) begin
            apply(2'(k), 32'hDEADBEEF, 1'b1, 0, 1'b1); chk("R5 reg0 c1", 32'hDEADBEEF, 1'b1);
            apply(2'(k), 32'h80000001, 1'b1, 0, 1'b0); chk("R5 reg0 c0", 32'h80000001, 1'b0);
        end
    endtask

    task automatic t_lsl;
        apply(2'b00, 32'h12345678, 1'b0, 4, 1'b0); chk("R6 lsl4", 32'h23456780, 1'b1);
        apply(2'b00, 32'h00000001, 1'b1, 32, 1'b0); chk("R6 lsl32", 32'h0, 1'b1);
        apply(2'b00, 32'hFFFFFFFF, 1'b1, 40, 1'b1); chk("R6 lsl40", 32'h0, 1'b0);
        apply(2'b00, 32'hCAFEF00D, 1'b0, 0, 1'b1); chk("R6 lsl imm0", 32'hCAFEF00D, 1'b1);
    endtask

    task automatic t_asr;
        apply(2'b10, 32'h80000010, 1'b0, 4, 1'b1); chk("R7 asr4", 32'hF8000001, 1'b0);
        apply(2'b10, 32'h80000000, 1'b0, 0, 1'b0); chk("R7 asr imm0", 32'hFFFFFFFF, 1'b1);
        apply(2'b10, 32'h40000000, 1'b1, 50, 1'b1); chk("R7 asr50", 32'h0, 1'b0);
    endtask

    task automatic t_ror;
        apply(2'b11, 32'h12345678, 1'b0, 8, 1'b1); chk("R8 ror8", 32'h78123456, 1'b0);
        apply(2'b11, 32'h12345678, 1'b1, 36, 1'b0); chk("R8 ror36", 32'h81234567, 1'b1);
        apply(2'b11, 32'h12345678, 1'b1, 32, 1'b1); chk("R8 ror32", 32'h12345678, 1'b0);
        apply(2'b11, 32'h00000003, 1'b0, 0, 1'b1); chk("R9 rrx c1", 32'h80000001, 1'b1);
        apply(2'b11, 32'h00000002, 1'b0, 0, 1'b0); chk("R9 rrx c0", 32'h00000001, 1'b0);
    endtask

    task automatic t_pc;
        // R10: amount from pc: (0x10+8)&mask = 24
        @(negedge clk);
        shift_kind = 2'b01; op_idx = 4'd1; op_data = 32'hFF000000;
        amt_from_reg = 1'b1; amt_idx = 4'd15; amt_data = 32'd1;
        pc_val = 32'h00000010; psr_bits = 32'hFC000003; carry_in = 1'b1;
        @(negedge clk); chk("R10 pc amount", 32'h000000FF, 1'b0);
        // R11: operand from pc merged with status, op_data ignored
        @(negedge clk);
        shift_kind = 2'b00; op_idx = 4'd15; op_data = 32'h55555555;
        amt_from_reg = 1'b0; amt_imm = 5'd0; amt_idx = 4'd2;
        pc_val = 32'h00001234; psr_bits = 32'hF0000003; carry_in = 1'b0;
        @(negedge clk); chk("R11 pc operand", 32'hF0001237, 1'b0);
        // R10 R11 together: advanced pc masks to zero -> pass-through
        @(negedge clk);
        shift_kind = 2'b01; op_idx = 4'd15; amt_from_reg = 1'b1; amt_idx = 4'd15;
        amt_data = 32'd5; pc_val = 32'h03FFFFF8; psr_bits = 32'hA8000001; carry_in = 1'b1;
        @(negedge clk); chk("R10 R11 combined", 32'hABFFFFF9, 1'b1);
    endtask

    task automatic t_random;
        logic [32:0] e;
        logic [31:0] v, a;
        logic [1:0] k;
        logic rs, ci;
        for (int i = 0; i < 300; i++) begin
            v = $urandom; k = 2'($urandom); rs = 1'($urandom); ci = 1'($urandom);
            a = (i % 3 == 0) ? 32'($urandom % 70) : (rs ? $urandom : 32'($urandom % 32));
            if (!rs) a = {27'd0, a[4:0]};
            apply(k, v, rs, a, ci);
            e = model(k, v, rs, a, ci);
            chk("R2 R6 R7 R8 random", e[31:0], e[32]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_lsr;
        t_reg_zero;
        t_lsl;
        t_asr;
        t_ror;
        t_pc;
        t_random;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule